// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Controller

This block is the interrupt front end of a 16550-style serial port. It holds the three-bit interrupt enable register, watches four request inputs (receiver line status, receive data available, character timeout and transmitter empty) and reports the most urgent enabled one. The report takes two forms. One is a four-bit identification code that the CPU reads. The other is a single interrupt line to the processor.

The source conditions themselves come from elsewhere in the UART. The FIFO levels, the error flags and the timeout timer all arrive here as level requests, and the source logic clears those requests. Only the transmitter-empty interrupt is latched inside this block. It is armed when the transmitter is empty and its enable is on. A CPU write of the transmit holding register clears it, and so does an identification read that reported it. With every enable cleared the port works in polled mode: the identification code stays at "nothing pending" and the interrupt line stays low.

The register accesses use a small address/strobe bus. The addresses of the enable, identification and transmit-holding registers are parameters. The code the CPU reads is captured on the first cycle of a read, and it does not change while the read strobe is held.

Top module: `uart_intr_ctrl`

## Requirements
- R1: In the cycle after synchronous reset, the enable readback is 0x00, the identification code is 4'b0001 and the interrupt line is low.
- R2: A write to the enable address stores data bits 2:0. Bit 0 enables receive data and timeout, bit 1 enables transmitter empty and bit 2 enables line status. Readback bits 7:3 are always 0.
- R3: When line status is requested and enabled, the code is 4'b0110, whatever the other requests are.
- R4: Without an enabled line-status request, an enabled receive-level request gives 4'b1100 if the timeout request is high and 4'b0100 otherwise. Either code outranks transmitter empty.
- R5: The transmitter-empty code 4'b0010 is reported only when no higher source is enabled and pending.
- R6: The transmitter-empty interrupt becomes pending on a cycle where (tx_empty AND enable bit 1) goes from 0 to 1. It is cleared by a write to the transmit-holding address, or by the first cycle of an identification read whose captured code is 4'b0010. A clear wins over a set in the same cycle.
- R7: A request whose enable bit is 0 has no effect on the code or on the interrupt line. With all enables 0, the code is 4'b0001 and the line is low.
- R8: The code and the line follow the request and enable state one clock later. The line is high exactly when some enabled source is pending, and code bit 0 is its inverse whenever no read is holding the code.
- R9: While the read strobe stays on the identification address past its first cycle, the code keeps the value captured in that first cycle.
- R10: An identification read that captures a code other than 4'b0010 leaves a pending transmitter-empty interrupt in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | DATA_W | Write data |
| line_err_req | input | 1 | Receiver line status request |
| rx_data_req | input | 1 | Receive data available request |
| rx_tmo_req | input | 1 | Character timeout request |
| tx_empty | input | 1 | Transmitter holding/FIFO empty level |
| ier_rdata | output | DATA_W | Enable register readback |
| iir_id | output | 4 | Interrupt identification code |
| intr | output | 1 | Interrupt line to the processor |

## Verification
The bench goes after the two ways the transmitter-empty latch can fail. A design that clears it on every identification read would lose the 4'b0010 code after a read that reported receive data. A design that sets it on the level and not on the edge would re-raise it at once after a THR write. The bench also holds a read for several cycles while it raises a line-status request, which catches a code that moves during the read. It writes all-ones to the enable register to expose unused bits that read back non-zero. It raises timeout and data-ready together, so a swapped level-2 choice shows up as the wrong code.

// File: rtl/uart_intr_pkg.sv
package uart_intr_pkg;

    localparam int IER_USED = 3;
    localparam int ID_W     = 4;

    typedef enum logic [ID_W-1:0] {
        IIR_NONE   = 4'b0001,
        IIR_THRE   = 4'b0010,
        IIR_RXDATA = 4'b0100,
        IIR_LINE   = 4'b0110,
        IIR_TMO    = 4'b1100
    } iir_id_e;

    // packed order follows the enable register bit positions (2..0)
    typedef struct packed {
        logic line_en;
        logic tx_en;
        logic rx_en;
    } irq_en_t;

    typedef struct packed {
        logic line_err;
        logic rx_tmo;
        logic rx_data;
        logic thre;
    } irq_src_t;

    function automatic iir_id_e pick_source(irq_en_t en, irq_src_t src);
        if (en.line_en && src.line_err)
            return IIR_LINE;
        if (en.rx_en && src.rx_tmo)
            return IIR_TMO;
        if (en.rx_en && src.rx_data)
            return IIR_RXDATA;
        if (en.tx_en && src.thre)
            return IIR_THRE;
        return IIR_NONE;
    endfunction

endpackage

// File: rtl/uart_intr_regs.sv
module uart_intr_regs
    import uart_intr_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int THR_ADDR = 0,
    parameter int IER_ADDR = 1,
    parameter int IIR_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output irq_en_t           ier_q,
    output logic              thr_wr,
    output logic              iir_rd_first,
    output logic              iir_rd_hold
);

    logic ier_wr;
    logic iir_rd;
    logic iir_rd_prev;
    logic unused_wdata_hi;

    assign ier_wr = cpu_wr && (cpu_addr == ADDR_W'(IER_ADDR));
    assign thr_wr = cpu_wr && (cpu_addr == ADDR_W'(THR_ADDR));
    assign iir_rd = cpu_rd && (cpu_addr == ADDR_W'(IIR_ADDR));

    assign iir_rd_first = iir_rd && !iir_rd_prev;
    assign iir_rd_hold  = iir_rd && iir_rd_prev;

    assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:IER_USED];

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q       <= '0;
            iir_rd_prev <= 1'b0;
        end else begin
            iir_rd_prev <= iir_rd;
            if (ier_wr)
                ier_q <= irq_en_t'(cpu_wdata[IER_USED-1:0]);
        end
    end

    // R2: an enable write lands in the register one edge later
    p_ier_load_r2: assert property (@(posedge clk) disable iff (rst)
        ier_wr |=> (ier_q == $past(cpu_wdata[IER_USED-1:0])));

endmodule

// File: rtl/uart_thre_track.sv
module uart_thre_track (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic tx_en,
    input  logic thr_wr,
    input  logic iir_rd_first,
    input  logic live_is_thre,
    output logic thre_pend
);

    logic arm;
    logic arm_prev;
    logic set_ev;
    logic clr_ev;

    assign arm    = tx_empty && tx_en;
    assign set_ev = arm && !arm_prev;
    assign clr_ev = thr_wr || (iir_rd_first && live_is_thre);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_prev  <= 1'b0;
            thre_pend <= 1'b0;
        end else begin
            arm_prev <= arm;
            if (clr_ev)
                thre_pend <= 1'b0;
            else if (set_ev)
                thre_pend <= 1'b1;
        end
    end

    // R6: a holding-register write always drops the pending flag
    p_thre_clr_r6: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !thre_pend);

    // R6: an arming edge without a clear raises the flag
    p_thre_set_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && tx_en && !arm_prev && !clr_ev) |=> thre_pend);

endmodule

// File: rtl/uart_intr_prio.sv
module uart_intr_prio
    import uart_intr_pkg::*;
(
    input  irq_en_t  en,
    input  irq_src_t src,
    output iir_id_e  live_id,
    output logic     any_pend
);

    assign live_id  = pick_source(en, src);
    assign any_pend = (live_id != IIR_NONE);

    // R3/R5: the reported code belongs to a source that is enabled and requesting
    always_comb begin
        if (live_id == IIR_LINE)
            p_line_valid_r3: assert (en.line_en && src.line_err);
        if (live_id == IIR_THRE)
            p_thre_lowest_r5: assert (en.tx_en && src.thre &&
                                      !(en.rx_en && (src.rx_data || src.rx_tmo)));
    end

endmodule

// File: rtl/uart_intr_ctrl.sv
module uart_intr_ctrl
    import uart_intr_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int THR_ADDR = 0,
    parameter int IER_ADDR = 1,
    parameter int IIR_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              line_err_req,
    input  logic              rx_data_req,
    input  logic              rx_tmo_req,
    input  logic              tx_empty,
    output logic [DATA_W-1:0] ier_rdata,
    output logic [ID_W-1:0]   iir_id,
    output logic              intr
);

    irq_en_t  ier_q;
    irq_src_t src;
    iir_id_e  live_id;
    logic     any_pend;
    logic     thr_wr;
    logic     iir_rd_first;
    logic     iir_rd_hold;
    logic     thre_pend;
    logic     hold_q;

    uart_intr_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .THR_ADDR(THR_ADDR),
        .IER_ADDR(IER_ADDR),
        .IIR_ADDR(IIR_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cpu_addr    (cpu_addr),
        .cpu_wr      (cpu_wr),
        .cpu_rd      (cpu_rd),
        .cpu_wdata   (cpu_wdata),
        .ier_q       (ier_q),
        .thr_wr      (thr_wr),
        .iir_rd_first(iir_rd_first),
        .iir_rd_hold (iir_rd_hold)
    );

    uart_thre_track u_thre (
        .clk         (clk),
        .rst         (rst),
        .tx_empty    (tx_empty),
        .tx_en       (ier_q.tx_en),
        .thr_wr      (thr_wr),
        .iir_rd_first(iir_rd_first),
        .live_is_thre(live_id == IIR_THRE),
        .thre_pend   (thre_pend)
    );

    always_comb begin
        src.line_err = line_err_req;
        src.rx_tmo   = rx_tmo_req;
        src.rx_data  = rx_data_req;
        src.thre     = thre_pend;
    end

    uart_intr_prio u_prio (
        .en      (ier_q),
        .src     (src),
        .live_id (live_id),
        .any_pend(any_pend)
    );

    assign ier_rdata = DATA_W'(ier_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            iir_id <= IIR_NONE;
            intr   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            intr   <= any_pend;
            hold_q <= iir_rd_hold;
            if (!iir_rd_hold)
                iir_id <= live_id;
        end
    end

    // R3: an enabled line-status request wins the next code
    p_line_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (ier_q.line_en && line_err_req && !iir_rd_hold) |=> (iir_id == IIR_LINE));

    // R7: polled mode keeps the line quiet
    p_polled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (ier_q == '0) |=> !intr);

    // R8: code bit 0 is the inverse of the line unless a read froze the code
    p_bit0_inv_r8: assert property (@(posedge clk) disable iff (rst)
        !hold_q |-> (iir_id[0] == !intr));

    // R9: a held read keeps the captured code
    p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        iir_rd_hold |=> $stable(iir_id));

endmodule

// File: tb/uart_intr_ctrl_tb.sv
module uart_intr_ctrl_tb;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] A_THR = 3'd0;
    localparam logic [ADDR_W-1:0] A_IER = 3'd1;
    localparam logic [ADDR_W-1:0] A_IIR = 3'd2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic [ADDR_W-1:0] cpu_addr;
    logic              cpu_wr;
    logic              cpu_rd;
    logic [DATA_W-1:0] cpu_wdata;
    logic              line_err_req;
    logic              rx_data_req;
    logic              rx_tmo_req;
    logic              tx_empty;
    logic [DATA_W-1:0] ier_rdata;
    logic [3:0]        iir_id;
    logic              intr;

    uart_intr_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .cpu_addr    (cpu_addr),
        .cpu_wr      (cpu_wr),
        .cpu_rd      (cpu_rd),
        .cpu_wdata   (cpu_wdata),
        .line_err_req(line_err_req),
        .rx_data_req (rx_data_req),
        .rx_tmo_req  (rx_tmo_req),
        .tx_empty    (tx_empty),
        .ier_rdata   (ier_rdata),
        .iir_id      (iir_id),
        .intr        (intr)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // expected code from the requirement priorities (R3, R4, R5, R7)
    function automatic logic [3:0] exp_code(logic [2:0] en, logic le, logic rd,
                                            logic to, logic th);
        if (en[2] && le) return 4'b0110;
        if (en[0] && to) return 4'b1100;
        if (en[0] && rd) return 4'b0100;
        if (en[1] && th) return 4'b0010;
        return 4'b0001;
    endfunction

    // reference state built from R2, R6, R8, R9
    logic [2:0] m_ier;
    logic       m_thre, m_arm, m_rdp, m_irq;
    logic [3:0] m_code;
    logic [3:0] m_live;
    logic       m_wr_thr, m_wr_ier, m_rd_iir;

    always @(posedge clk) begin
        m_live   = exp_code(m_ier, line_err_req, rx_data_req, rx_tmo_req, m_thre);
        m_wr_thr = cpu_wr && cpu_addr == A_THR;
        m_wr_ier = cpu_wr && cpu_addr == A_IER;
        m_rd_iir = cpu_rd && cpu_addr == A_IIR;
        if (rst) begin
            m_ier <= '0; m_thre <= 1'b0; m_arm <= 1'b0; m_rdp <= 1'b0;
            m_irq <= 1'b0; m_code <= 4'b0001;
        end else begin
            m_arm <= tx_empty && m_ier[1];
            if (m_wr_thr || (m_rd_iir && !m_rdp && m_live == 4'b0010))
                m_thre <= 1'b0;
            else if (tx_empty && m_ier[1] && !m_arm)
                m_thre <= 1'b1;
            if (m_wr_ier) m_ier <= cpu_wdata[2:0];
            m_rdp <= m_rd_iir;
            if (!(m_rd_iir && m_rdp)) m_code <= m_live;
            m_irq <= (m_live != 4'b0001);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        cyc();
        cpu_wr = 1'b0;
    endtask

    task automatic iir_read_once(logic [3:0] exp, string tag);
        cpu_addr = A_IIR; cpu_rd = 1'b1;
        cyc();
        cpu_rd = 1'b0;
        chk(tag, iir_id, exp);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cpu_addr = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = '0;
        line_err_req = 1'b0; rx_data_req = 1'b0; rx_tmo_req = 1'b0; tx_empty = 1'b0;
        cyc(3);
        rst = 1'b0;
        chk("R1 ier after reset", ier_rdata, 8'h00);
        chk("R1 iir after reset", iir_id, 4'b0001);
        chk("R1 intr after reset", intr, 1'b0);

        bus_write(A_IER, 8'hFF);
        chk("R2 unused enable bits read 0", ier_rdata, 8'h07);

        bus_write(A_IER, 8'h00);
        line_err_req = 1; rx_data_req = 1; rx_tmo_req = 1; tx_empty = 1;
        cyc(2);
        chk("R7 polled code", iir_id, 4'b0001);
        chk("R7 polled intr", intr, 1'b0);

        rx_tmo_req = 0;
        bus_write(A_IER, 8'h07);
        cyc(2);
        chk("R3 line status wins", iir_id, 4'b0110);

        line_err_req = 0; cyc(2);
        chk("R4 data ready", iir_id, 4'b0100);
        rx_tmo_req = 1; cyc(2);
        chk("R4 timeout with data ready", iir_id, 4'b1100);

        rx_data_req = 0; rx_tmo_req = 0; cyc(2);
        chk("R5 transmitter empty code", iir_id, 4'b0010);
        chk("R8 intr with pending source", intr, 1'b1);

        iir_read_once(4'b0010, "R6 read reports thre");
        cyc(2);
        chk("R6 read clears thre", iir_id, 4'b0001);
        chk("R8 intr drops", intr, 1'b0);

        bus_write(A_IER, 8'h00);
        bus_write(A_IER, 8'h02);
        cyc(2);
        chk("R6 enable edge re-arms thre", iir_id, 4'b0010);
        bus_write(A_THR, 8'h5A);
        cyc(2);
        chk("R6 holding write clears thre", iir_id, 4'b0001);

        bus_write(A_IER, 8'h00);
        bus_write(A_IER, 8'h03);
        rx_data_req = 1; cyc(2);
        chk("R10 data ready over thre", iir_id, 4'b0100);
        iir_read_once(4'b0100, "R10 read captures data ready");
        rx_data_req = 0; cyc(2);
        chk("R10 thre survives other read", iir_id, 4'b0010);
        iir_read_once(4'b0010, "R6 second clear read");
        cyc(2);

        bus_write(A_IER, 8'h07);
        rx_data_req = 1; cyc(2);
        chk("R9 before held read", iir_id, 4'b0100);
        cpu_addr = A_IIR; cpu_rd = 1'b1;
        cyc();
        chk("R9 captured code", iir_id, 4'b0100);
        line_err_req = 1;
        cyc(3);
        chk("R9 code frozen during read", iir_id, 4'b0100);
        cpu_rd = 1'b0;
        cyc(2);
        chk("R3 line status after read", iir_id, 4'b0110);
        line_err_req = 0; rx_data_req = 0;
        cyc(2);

        begin
            int rd_left = 0;
            for (int i = 0; i < 4000; i++) begin
                cyc();
                chk("R8 model intr", intr, m_irq);
                chk("R8 model code", iir_id, m_code);
                chk("R2 model ier", ier_rdata, {5'b0, m_ier});
                line_err_req = (($urandom % 8) == 0);
                rx_data_req  = (($urandom % 4) == 0);
                rx_tmo_req   = (($urandom % 6) == 0);
                if (($urandom % 10) == 0) tx_empty = ~tx_empty;
                cpu_wr = 1'b0;
                if (rd_left > 0) begin
                    rd_left--;
                    if (rd_left == 0) cpu_rd = 1'b0;
                end else begin
                    cpu_rd = 1'b0;
                    case ($urandom % 8)
                        0: begin cpu_wr = 1; cpu_addr = A_IER; cpu_wdata = 8'($urandom); end
                        1: begin cpu_wr = 1; cpu_addr = A_THR; cpu_wdata = 8'($urandom); end
                        2: begin cpu_rd = 1; cpu_addr = A_IIR; rd_left = 1 + int'($urandom % 3); end
                        3: begin cpu_rd = 1; cpu_addr = A_THR; rd_left = 1; end
                        default: ;
                    endcase
                end
            end
        end
        cpu_wr = 0; cpu_rd = 0;
        cyc(2);
        summary();
    end

endmodule